// File: doc/BRIEF.md
# Extended-Precision Add/Subtract Special-Operand Resolver

This combinational block settles an 80-bit extended add or subtract whenever at least one operand is not a plain normal number. Each operand comes with a class tag. Operand B also comes with an effective sign, which already includes the subtract inversion. The block also takes the rounding and precision fields of the control word. From these it either produces the final result word and class, or reports that the pair has to go elsewhere.

Pairs that contain a NaN raise a dispatch flag for a separate NaN unit. Pairs of finite non-zero operands raise a request for the normal arithmetic datapath, where they are widened and added. Every other pairing is resolved here:

- signed zeros,
- zero with a number,
- the infinity cases, including infinity minus infinity,
- repair of pseudo-denormals,
- detection of denormal operands and of underflow on a denormal result.

Word layout: bit 79 is the sign, bits 78:64 are the biased exponent and bits 63:0 are the significand, which carries an explicit integer bit at bit 63.

Top module: `fp_special_addsub`

## Requirements
- R1: Class tags are encoded valid=0, zero=1, denormal=2, infinity=3, NaN=4. Codes 5 to 7 are also treated as NaN. If either tag is 4 or above, `nan_dispatch` is 1, every other flag is 0, `res_word` is all zeros and `res_tag` is 4, whatever the other operand is.
- R2: If both tags are in {valid, denormal} and neither is NaN, `normal_path` is 1, `res_word` is zero, `res_tag` is 0 and `invalid_op` is 0.
- R3: When no NaN is present, `denorm_op` is 1 exactly when at least one tag is 2. This holds both for pairs sent to the normal path and for pairs resolved here.
- R4: Zero plus zero with equal signs gives a zero of that common sign, with `res_tag` 1. The sign of A is bit 79 of `op_a`; the sign of B is `sign_b_eff`.
- R5: Zero plus zero with different signs gives +0, except when `rnd_mode` is 2'b01 (round down), which gives -0. `res_tag` is 1.
- R6: Zero combined with a finite non-zero operand returns the non-zero operand's exponent and significand unchanged, with its own tag. The sign is bit 79 for A and `sign_b_eff` for B.
- R7: A returned operand tagged denormal with significand bit 63 set is a pseudo-denormal. It is returned with its exponent raised by one and `res_tag` 0. A result tagged denormal therefore never has bit 63 set.
- R8: An infinity combined with a finite operand, or with an infinity of the same effective sign, returns that infinity with its effective sign and `res_tag` 3.
- R9: Infinities of opposite effective signs set `invalid_op` and return the indefinite word: sign 1, exponent 0x7FFF, significand 0xC000_0000_0000_0000. `res_tag` is 4.
- R10: `underflow` is 1 only when the result is tagged denormal and precision trimming would drop non-zero bits. With `prec_mode` 2'b00 (24-bit), the dropped bits are significand bits 39:0. With 2'b10 (53-bit), they are bits 10:0. Modes 2'b11 and 2'b01 keep all 64 bits and never signal underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 80 | Operand A word (sign, exponent, significand) |
| tag_a | input | 3 | Class tag of operand A |
| op_b | input | 80 | Operand B word; its sign bit is ignored |
| tag_b | input | 3 | Class tag of operand B |
| sign_b_eff | input | 1 | Effective sign of operand B |
| rnd_mode | input | 2 | Rounding field; 2'b01 means round down |
| prec_mode | input | 2 | Precision field: 00 = 24-bit, 10 = 53-bit, 11 or 01 = 64-bit |
| res_word | output | 80 | Resolved result word |
| res_tag | output | 3 | Class tag of the result |
| invalid_op | output | 1 | Invalid operation (opposite infinities) |
| denorm_op | output | 1 | A denormal operand was seen |
| normal_path | output | 1 | Pair must go to the normal arithmetic datapath |
| nan_dispatch | output | 1 | Pair contains a NaN and goes to the NaN unit |
| underflow | output | 1 | Denormal result loses bits at the selected precision |

## Verification
The bench targets the following corner cases, each chosen to expose a specific fault:

- **Signed zero sums under every rounding mode.** A design that tied the sign to a single operand would return -0 in round-to-nearest, or +0 in round-down.
- **Opposite infinities alongside same-sign infinities.** A design that ignored the effective sign of B would flag `invalid_op` on a legal subtraction, or miss the indefinite result.
- **Pseudo-denormals returned through a zero.** A design without the repair would report a denormal tag whose integer bit is set, with an exponent that is one too small.
- **Denormal results at each precision, with dropped bits just inside and just outside the cut.** A design with a misplaced cut would signal underflow in the wrong cases.
- **NaNs paired with operands that would otherwise raise flags.** A design with the wrong priority would let `invalid_op` or `denorm_op` leak past the NaN dispatch.

// File: rtl/fpsar_pkg.sv
`timescale 1ns/1ps
package fpsar_pkg;
  localparam int EXP_W  = 15;
  localparam int SIG_W  = 64;
  localparam int WORD_W = 1 + EXP_W + SIG_W;
  localparam int TAG_W  = 3;
  localparam int SGL_KEEP = 24;
  localparam int DBL_KEEP = 53;
  localparam int SGL_DROP = SIG_W - SGL_KEEP;
  localparam int DBL_DROP = SIG_W - DBL_KEEP;

  localparam logic [TAG_W-1:0] TAG_VALID  = 3'd0;
  localparam logic [TAG_W-1:0] TAG_ZERO   = 3'd1;
  localparam logic [TAG_W-1:0] TAG_DENORM = 3'd2;
  localparam logic [TAG_W-1:0] TAG_INF    = 3'd3;
  localparam logic [TAG_W-1:0] TAG_NAN    = 3'd4;

  localparam logic [1:0] RND_DOWN = 2'b01;
  localparam logic [1:0] PREC_SGL = 2'b00;
  localparam logic [1:0] PREC_DBL = 2'b10;

  localparam logic [WORD_W-1:0] INDEF_WORD =
    {1'b1, {EXP_W{1'b1}}, 2'b11, {(SIG_W-2){1'b0}}};

  typedef enum logic [2:0] {
    SEL_NAN, SEL_NORMAL, SEL_ZERO_ZERO, SEL_PASS_A,
    SEL_PASS_B, SEL_INF_A, SEL_INF_B, SEL_INVALID
  } sel_e;

  // Sign of an exact zero sum.
  function automatic logic zero_sum_sign(input logic sa, input logic sb,
                                         input logic [1:0] rnd);
    return (sa == sb) ? sa : (rnd == RND_DOWN);
  endfunction

  // Would trimming the significand to the given precision drop set bits?
  function automatic logic lost_bits(input logic [SIG_W-1:0] m,
                                     input logic [1:0] prec);
    case (prec)
      PREC_SGL: return |m[SGL_DROP-1:0];
      PREC_DBL: return |m[DBL_DROP-1:0];
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/fpsar_operand.sv
`timescale 1ns/1ps
module fpsar_operand
  import fpsar_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [TAG_W-1:0]  tag,
  input  logic              eff_sign,
  output logic              is_zero,
  output logic              is_den,
  output logic              is_inf,
  output logic              is_nan,
  output logic              is_fin_nz,
  output logic [WORD_W-1:0] pass_word,
  output logic [TAG_W-1:0]  pass_tag
);
  logic [EXP_W-1:0] exp_f;
  logic [SIG_W-1:0] sig_f;
  logic             pseudo;

  assign exp_f = word[WORD_W-2:SIG_W];
  assign sig_f = word[SIG_W-1:0];

  always_comb begin
    is_nan    = (tag >= TAG_NAN);
    is_zero   = (tag == TAG_ZERO);
    is_den    = (tag == TAG_DENORM);
    is_inf    = (tag == TAG_INF);
    is_fin_nz = (tag == TAG_VALID) || (tag == TAG_DENORM);
    pseudo    = is_den && sig_f[SIG_W-1];
    pass_word = {eff_sign, pseudo ? exp_f + 1'b1 : exp_f, sig_f};
    pass_tag  = pseudo ? TAG_VALID : tag;
  end
endmodule

// File: rtl/fpsar_dispatch.sv
`timescale 1ns/1ps
module fpsar_dispatch
  import fpsar_pkg::*;
(
  input  logic a_zero, a_den, a_inf, a_nan, a_fnz, sign_a,
  input  logic b_zero, b_den, b_inf, b_nan, b_fnz, sign_b,
  output sel_e sel,
  output logic denorm_seen
);
  logic any_nan;
  assign any_nan = a_nan | b_nan;

  always_comb begin
    if (any_nan)                sel = SEL_NAN;
    else if (a_fnz && b_fnz)    sel = SEL_NORMAL;
    else if (a_zero && !b_inf)  sel = b_zero ? SEL_ZERO_ZERO : SEL_PASS_B;
    else if (b_zero && !a_inf)  sel = SEL_PASS_A;
    else if (a_inf)             sel = (!b_inf || sign_a == sign_b) ? SEL_INF_A : SEL_INVALID;
    else                        sel = SEL_INF_B;
    denorm_seen = (a_den | b_den) & ~any_nan;
  end
endmodule

// File: rtl/fpsar_uflow.sv
`timescale 1ns/1ps
module fpsar_uflow
  import fpsar_pkg::*;
(
  input  logic [TAG_W-1:0] tag,
  input  logic [SIG_W-1:0] sig,
  input  logic [1:0]       prec,
  output logic             uflow
);
  assign uflow = (tag == TAG_DENORM) && lost_bits(sig, prec);
endmodule

// File: rtl/fp_special_addsub.sv
`timescale 1ns/1ps
module fp_special_addsub
  import fpsar_pkg::*;
(
  input  logic [79:0] op_a,
  input  logic [2:0]  tag_a,
  input  logic [79:0] op_b,
  input  logic [2:0]  tag_b,
  input  logic        sign_b_eff,
  input  logic [1:0]  rnd_mode,
  input  logic [1:0]  prec_mode,
  output logic [79:0] res_word,
  output logic [2:0]  res_tag,
  output logic        invalid_op,
  output logic        denorm_op,
  output logic        normal_path,
  output logic        nan_dispatch,
  output logic        underflow
);
  localparam int NOPS = 2;

  logic [WORD_W-1:0] words  [NOPS];
  logic [TAG_W-1:0]  tags   [NOPS];
  logic              signs  [NOPS];
  logic              zro    [NOPS];
  logic              den    [NOPS];
  logic              inf    [NOPS];
  logic              nan    [NOPS];
  logic              fnz    [NOPS];
  logic [WORD_W-1:0] pword  [NOPS];
  logic [TAG_W-1:0]  ptag   [NOPS];

  assign words[0] = op_a;
  assign words[1] = op_b;
  assign tags[0]  = tag_a;
  assign tags[1]  = tag_b;
  assign signs[0] = op_a[WORD_W-1];
  assign signs[1] = sign_b_eff;

  for (genvar i = 0; i < NOPS; i++) begin : g_op
    fpsar_operand u_op (
      .word(words[i]), .tag(tags[i]), .eff_sign(signs[i]),
      .is_zero(zro[i]), .is_den(den[i]), .is_inf(inf[i]),
      .is_nan(nan[i]), .is_fin_nz(fnz[i]),
      .pass_word(pword[i]), .pass_tag(ptag[i])
    );
  end

  sel_e sel;
  logic denorm_seen;

  fpsar_dispatch u_disp (
    .a_zero(zro[0]), .a_den(den[0]), .a_inf(inf[0]), .a_nan(nan[0]),
    .a_fnz(fnz[0]), .sign_a(signs[0]),
    .b_zero(zro[1]), .b_den(den[1]), .b_inf(inf[1]), .b_nan(nan[1]),
    .b_fnz(fnz[1]), .sign_b(signs[1]),
    .sel(sel), .denorm_seen(denorm_seen)
  );

  always_comb begin
    res_word     = '0;
    res_tag      = TAG_VALID;
    invalid_op   = 1'b0;
    normal_path  = 1'b0;
    nan_dispatch = 1'b0;
    case (sel)
      SEL_NAN: begin
        res_tag      = TAG_NAN;
        nan_dispatch = 1'b1;
      end
      SEL_NORMAL:    normal_path = 1'b1;
      SEL_ZERO_ZERO: begin
        res_word = {zero_sum_sign(signs[0], signs[1], rnd_mode), {(WORD_W-1){1'b0}}};
        res_tag  = TAG_ZERO;
      end
      SEL_PASS_A: begin
        res_word = pword[0];
        res_tag  = ptag[0];
      end
      SEL_PASS_B: begin
        res_word = pword[1];
        res_tag  = ptag[1];
      end
      SEL_INF_A: begin
        res_word = pword[0];
        res_tag  = TAG_INF;
      end
      SEL_INF_B: begin
        res_word = pword[1];
        res_tag  = TAG_INF;
      end
      default: begin
        res_word   = INDEF_WORD;
        res_tag    = TAG_NAN;
        invalid_op = 1'b1;
      end
    endcase
  end

  assign denorm_op = denorm_seen;

  fpsar_uflow u_uf (
    .tag(res_tag), .sig(res_word[SIG_W-1:0]), .prec(prec_mode), .uflow(underflow)
  );

  always_comb begin
    // R1
    nan_excl_chk: assert (!nan_dispatch || !(invalid_op | denorm_op | normal_path | underflow));
    // R2
    normal_valid_chk: assert (!normal_path || (!invalid_op && res_tag == TAG_VALID));
    // R9
    invalid_indef_chk: assert (!invalid_op || (res_word == INDEF_WORD && res_tag == TAG_NAN));
    // R7
    pseudo_fixed_chk: assert (res_tag != TAG_DENORM || !res_word[SIG_W-1]);
    // R10
    uflow_tag_chk: assert (!underflow || res_tag == TAG_DENORM);
  end
endmodule

// File: tb/fp_special_addsub_tb.sv
`timescale 1ns/1ps
module fp_special_addsub_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [79:0] op_a = '0, op_b = '0;
  logic [2:0]  tag_a = 3'd1, tag_b = 3'd1;
  logic        sign_b_eff = 1'b0;
  logic [1:0]  rnd_mode = 2'b00, prec_mode = 2'b11;
  logic [79:0] res_word;
  logic [2:0]  res_tag;
  logic        invalid_op, denorm_op, normal_path, nan_dispatch, underflow;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  fp_special_addsub dut_i (
    .op_a(op_a), .tag_a(tag_a), .op_b(op_b), .tag_b(tag_b),
    .sign_b_eff(sign_b_eff), .rnd_mode(rnd_mode), .prec_mode(prec_mode),
    .res_word(res_word), .res_tag(res_tag), .invalid_op(invalid_op),
    .denorm_op(denorm_op), .normal_path(normal_path),
    .nan_dispatch(nan_dispatch), .underflow(underflow)
  );

  // Behavioural reference, written from the requirement list.
  task automatic model(output logic [79:0] w, output logic [2:0] t,
                       output logic [4:0] fl, output string req);
    logic sa, sb, s, iv, dn, np, nd, uf;
    logic [79:0] o;
    int ot;
    int ta = tag_a;
    int tb = tag_b;
    sa = op_a[79]; sb = sign_b_eff;
    w = '0; t = 3'd0; iv = 0; dn = 0; np = 0; nd = 0; uf = 0; req = "R6";
    if (ta >= 4 || tb >= 4) begin
      t = 3'd4; nd = 1; req = "R1";
    end else begin
      dn = (ta == 2) || (tb == 2);
      if ((ta == 0 || ta == 2) && (tb == 0 || tb == 2)) begin
        np = 1; req = "R2";
      end else if (ta == 3 && tb == 3 && sa != sb) begin
        iv = 1; t = 3'd4; w = {1'b1, 15'h7FFF, 64'hC000_0000_0000_0000}; req = "R9";
      end else if (ta == 3) begin
        w = {sa, op_a[78:0]}; t = 3'd3; req = "R8";
      end else if (tb == 3) begin
        w = {sb, op_b[78:0]}; t = 3'd3; req = "R8";
      end else if (ta == 1 && tb == 1) begin
        w = {(sa == sb) ? sa : (rnd_mode == 2'b01), 79'b0}; t = 3'd1;
        req = (sa == sb) ? "R4" : "R5";
      end else begin
        if (ta == 1) begin o = op_b; s = sb; ot = tb; end
        else         begin o = op_a; s = sa; ot = ta; end
        if (ot == 2 && o[63]) begin
          w = {s, o[78:64] + 15'd1, o[63:0]}; t = 3'd0; req = "R7";
        end else begin
          w = {s, o[78:0]}; t = ot[2:0];
        end
        if (t == 3'd2) begin
          if (prec_mode == 2'b00) uf = |o[39:0];
          if (prec_mode == 2'b10) uf = |o[10:0];
          req = "R10";
        end
      end
      if (dn && req == "R6") req = "R3";
    end
    fl = {iv, dn, np, nd, uf};
  endtask

  task automatic check_now(input string note);
    logic [79:0] ew; logic [2:0] et; logic [4:0] ef; string req;
    logic [4:0] af;
    model(ew, et, ef, req);
    af = {invalid_op, denorm_op, normal_path, nan_dispatch, underflow};
    n_checks++;
    if (res_word !== ew || res_tag !== et || af !== ef) begin
      n_fail++;
      $display("FAIL %s (%s): word=%h tag=%0d flags=%b expected word=%h tag=%0d flags=%b",
               req, note, res_word, res_tag, af, ew, et, ef);
    end
  endtask

  task automatic apply(input logic [79:0] a, input logic [2:0] ta,
                       input logic [79:0] b, input logic [2:0] tb,
                       input logic sb, input logic [1:0] rm, input logic [1:0] pm,
                       input string note);
    @(posedge clk);
    #1;
    op_a = a; tag_a = ta; op_b = b; tag_b = tb;
    sign_b_eff = sb; rnd_mode = rm; prec_mode = pm;
    @(negedge clk);
    check_now(note);
  endtask

  function automatic logic [79:0] mk(input logic [2:0] t, input logic s);
    logic [14:0] e; logic [63:0] m;
    m = {$urandom, $urandom};
    case (t)
      3'd0: begin e = 15'(1 + ($urandom % 32766)); m[63] = 1'b1; end
      3'd1: begin e = '0; m = '0; end
      3'd2: begin e = '0; if (m == 0) m = 64'd1; end
      3'd3: begin e = '1; m = 64'h8000_0000_0000_0000; end
      default: begin e = '1; m[63:62] = 2'b11; end
    endcase
    return {s, e, m};
  endfunction

  localparam logic [79:0] PZ   = 80'h0;
  localparam logic [79:0] NZ   = {1'b1, 79'h0};
  localparam logic [79:0] PINF = {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000};
  localparam logic [79:0] VAL  = {1'b0, 15'h3FFF, 64'hC000_0000_0000_0001};

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_now("R4 zero pair held during reset");
    rst_n = 1'b1;
    // R4 equal-sign zeros
    apply(NZ, 3'd1, PZ, 3'd1, 1'b1, 2'b00, 2'b11, "R4 -0 + -0");
    // R5 differing signs under each rounding mode
    apply(PZ, 3'd1, PZ, 3'd1, 1'b1, 2'b00, 2'b11, "R5 nearest");
    apply(NZ, 3'd1, PZ, 3'd1, 1'b0, 2'b01, 2'b11, "R5 down");
    apply(PZ, 3'd1, PZ, 3'd1, 1'b1, 2'b10, 2'b11, "R5 up");
    apply(NZ, 3'd1, PZ, 3'd1, 1'b0, 2'b11, 2'b11, "R5 chop");
    // R6 zero with a number
    apply(PZ, 3'd1, VAL, 3'd0, 1'b1, 2'b00, 2'b11, "R6 b passes with effective sign");
    apply({1'b1, VAL[78:0]}, 3'd0, NZ, 3'd1, 1'b0, 2'b00, 2'b11, "R6 a passes");
    // R7 pseudo-denormal through a zero
    apply(PZ, 3'd1, {1'b0, 15'h0, 64'h8000_0000_0000_1234}, 3'd2, 1'b0, 2'b00, 2'b11, "R7 pseudo b");
    apply({1'b1, 15'h0, 64'hFFFF_0000_0000_0000}, 3'd2, PZ, 3'd1, 1'b0, 2'b00, 2'b00, "R7 pseudo a");
    // R8 infinities
    apply(PINF, 3'd3, VAL, 3'd0, 1'b1, 2'b00, 2'b11, "R8 inf + finite");
    apply(PINF, 3'd3, PINF, 3'd3, 1'b0, 2'b00, 2'b11, "R8 same-sign infs");
    apply(VAL, 3'd0, PINF, 3'd3, 1'b1, 2'b00, 2'b11, "R8 b inf");
    apply(PZ, 3'd1, PINF, 3'd3, 1'b1, 2'b00, 2'b11, "R8 zero + inf");
    // R9 opposite infinities
    apply(PINF, 3'd3, PINF, 3'd3, 1'b1, 2'b00, 2'b11, "R9 inf - inf");
    // R1 NaN priority
    apply(PINF, 3'd4, PINF, 3'd3, 1'b1, 2'b00, 2'b11, "R1 nan a");
    apply(mk(3'd2, 0), 3'd2, mk(3'd6, 0), 3'd6, 1'b0, 2'b00, 2'b00, "R1 code 6 over denormal");
    // R2 / R3
    apply(VAL, 3'd0, mk(3'd2, 0), 3'd2, 1'b0, 2'b00, 2'b11, "R2 valid+denormal");
    apply(VAL, 3'd0, VAL, 3'd0, 1'b1, 2'b00, 2'b11, "R2 valid+valid");
    apply(PZ, 3'd1, {1'b0, 15'h0, 64'h0000_0000_0001_0000}, 3'd2, 1'b0, 2'b00, 2'b11, "R3 zero+denormal");
    // R10 precision cuts
    apply(PZ, 3'd1, {1'b0, 15'h0, 64'h0000_0000_0000_0001}, 3'd2, 1'b0, 2'b00, 2'b00, "R10 single lost");
    apply(PZ, 3'd1, {1'b0, 15'h0, 64'h0000_0100_0000_0000}, 3'd2, 1'b0, 2'b00, 2'b00, "R10 single exact");
    apply(PZ, 3'd1, {1'b0, 15'h0, 64'h0000_0080_0000_0000}, 3'd2, 1'b0, 2'b00, 2'b00, "R10 single bit39");
    apply(PZ, 3'd1, {1'b0, 15'h0, 64'h0000_0000_0000_0400}, 3'd2, 1'b0, 2'b00, 2'b10, "R10 double lost");
    apply(PZ, 3'd1, {1'b0, 15'h0, 64'h0000_0000_0000_0800}, 3'd2, 1'b0, 2'b00, 2'b10, "R10 double exact");
    apply(PZ, 3'd1, {1'b0, 15'h0, 64'h0000_0000_0000_0001}, 3'd2, 1'b0, 2'b00, 2'b11, "R10 extended");
    apply(PZ, 3'd1, {1'b0, 15'h0, 64'h0000_0000_0000_0001}, 3'd2, 1'b0, 2'b00, 2'b01, "R10 reserved");
    // Random sweep over all class pairs
    for (int k = 0; k < 400; k++) begin
      logic [2:0] ta, tb;
      ta = 3'($urandom % 8); tb = 3'($urandom % 8);
      if (($urandom % 4) != 0 && ta > 3) ta = 3'($urandom % 4);
      if (($urandom % 4) != 0 && tb > 3) tb = 3'($urandom % 4);
      apply(mk(ta, 1'($urandom)), ta, mk(tb, 1'($urandom)), tb, 1'($urandom),
            2'($urandom), 2'($urandom), "random sweep");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule